// File: doc/BRIEF.md
# Writer-Push Home Directory Engine

This block is the home-side controller for a small group of caching sites that share one memory under a writer-push coherence scheme. For every address it holds the memory word and a bit vector of the sites that currently keep a copy. The vector can hold at most `SLOTS` sites at a time. Sites send fetch requests, writebacks and voluntary push commands on a request channel. That channel is buffered in a small FIFO and handled strictly in arrival order. Purge and demotion acknowledgements come back on a separate acknowledgement channel. The engine answers on one outgoing message channel: data replies, purge requests, demotion requests and writeback releases. Every channel uses a valid/ready handshake.

The controller handles one transaction at a time.

- **Fetch:** a fetch is answered with the memory word, and the requester is recorded as a sharer. If the requester is not yet a sharer and the vector is already full, the lowest-numbered sharer is first sent a demotion request. That site drops to the directory-less base scheme. Its slot is freed only when its acknowledgement arrives, and only then is the fetch answered.
- **Writeback:** the other sharers are sent purge requests in ascending site order and are removed from the vector. Once every purge acknowledgement has returned, memory takes the new word and the writer becomes the only sharer. The writer then receives a release message that ends its pending state.
- **Voluntary push:** a push command sends a clean copy to a site that does not hold one and records that site as a sharer.

States of the controller:

- IDLE: pops the next request.
- DECIDE: classifies the request.
- REPLY: sends the data reply and records the sharer.
- DG_SEND: sends the demotion request.
- DG_WAIT: waits for the victim's acknowledgement.
- PURGE_SEND: sends the purge requests.
- PURGE_WAIT: waits for the outstanding purge acknowledgements.
- COMMIT: writes memory and the vector.
- RELEASE: sends the release to the writer.

Transitions:

- IDLE to DECIDE when the FIFO holds a request.
- DECIDE to REPLY for a serviceable fetch or push.
- DECIDE to DG_SEND for a fetch that hits a full vector.
- DECIDE to PURGE_SEND for a writeback that has other sharers.
- DECIDE to COMMIT for a writeback with no other sharers.
- DECIDE to IDLE for a push that is ignored.
- DG_SEND to DG_WAIT when the demotion request is accepted.
- DG_WAIT to REPLY when the victim acknowledges.
- PURGE_SEND to PURGE_WAIT when the last purge request is accepted.
- PURGE_WAIT to COMMIT when no acknowledgement is outstanding.
- COMMIT to RELEASE.
- REPLY to IDLE and RELEASE to IDLE when the message is accepted.

Top module: `home_dir_engine`

## Requirements
- R1: After reset no message is offered, `req_ready` is high, and every memory word reads as zero.
- R2: A fetch (request kind 0) is answered with a data message (kind 0) to the requester, carrying the current memory word of that address. The requester is recorded as a sharer, and other addresses are unaffected.
- R3: A writeback (request kind 1) by a site while other sites share the address produces one purge request (kind 1) per other sharer, in ascending site number. Those sites are removed from the sharer vector.
- R4: No release is sent while a purge acknowledgement (ack kind 0) is outstanding. After the last one, memory holds the written word and the writer receives a release (kind 3) carrying that word. The writer is then the only sharer.
- R5: A writeback with no other sharer is released directly, with no purge request.
- R6: A request that arrives while purges are outstanding is served only after the release, and it sees the new word.
- R7: A fetch from a non-sharer when `SLOTS` sites already share the address first sends a demotion request (kind 2) to the lowest-numbered sharer. The data reply follows only after that site's demotion acknowledgement (ack kind 1), and the demoted site is no longer tracked.
- R8: A voluntary push (request kind 2) to a non-sharer with a free slot sends a data message to that site and records it as a sharer. A push to a site that already shares the address, or to a full vector, sends nothing.
- R9: An offered message keeps all its fields while `msg_ready` is low. Requests are served in arrival order, and `req_ready` falls when the request FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request FIFO has room |
| req_kind | input | 2 | 0 fetch, 1 writeback, 2 voluntary push |
| req_site | input | SITE_W | Requesting or target site |
| req_addr | input | ADDR_W | Address |
| req_data | input | DATA_W | Written word (writeback) |
| ack_valid | input | 1 | Acknowledgement offered |
| ack_ready | output | 1 | Always high |
| ack_kind | input | 1 | 0 purge done, 1 demotion done |
| ack_site | input | SITE_W | Acknowledging site |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_kind | output | 2 | 0 data, 1 purge, 2 demote, 3 release |
| msg_site | output | SITE_W | Destination site |
| msg_addr | output | ADDR_W | Address |
| msg_data | output | DATA_W | Memory or written word |

## Verification
Fetches are tried in three situations: against a vector with free slots, against a full vector, and on an untouched address. Comparing the replies with the demotion path separates slot accounting from plain lookup. Writebacks are tried with no other sharer, with two other sharers, and with a sharer that arrived by voluntary push. This shows whether purges target exactly the right sites in the right order and whether pushed sites are really recorded. A fetch queued behind a writeback, together with long stalls on `msg_ready`, distinguishes correct holding and ordering from early service or changing message fields.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        RQ_FETCH     = 2'd0,
        RQ_WRITEBACK = 2'd1,
        RQ_PUSH      = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA    = 2'd0,
        MS_PURGE   = 2'd1,
        MS_DEMOTE  = 2'd2,
        MS_RELEASE = 2'd3
    } msg_kind_e;

    typedef enum logic {
        AK_PURGE  = 1'b0,
        AK_DEMOTE = 1'b1
    } ack_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_REPLY,
        ST_DG_SEND,
        ST_DG_WAIT,
        ST_PURGE_SEND,
        ST_PURGE_WAIT,
        ST_COMMIT,
        ST_RELEASE
    } hd_state_e;

endpackage

// File: rtl/hd_fifo.sv
module hd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [WIDTH-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_pop,
    output logic [WIDTH-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [PTR_W:0]   count;
    logic             do_wr, do_rd;

    assign wr_ready = (count != (PTR_W+1)'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_data  = slots[rptr];
    assign do_wr    = wr_valid && wr_ready;
    assign do_rd    = rd_pop && rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) begin
                slots[wptr] <= wr_data;
                wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (do_rd) begin
                rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
            end
            count <= count + (PTR_W+1)'(do_wr) - (PTR_W+1)'(do_rd);
        end
    end
endmodule

// File: rtl/hd_dir.sv
module hd_dir #(
    parameter int NUM_SITES = 4,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    rd_word,
    output logic [NUM_SITES-1:0] rd_shr,
    input  logic                 word_we,
    input  logic [DATA_W-1:0]    word_wdata,
    input  logic                 shr_we,
    input  logic [NUM_SITES-1:0] shr_wdata
);
    localparam int ENTRIES = 1 << ADDR_W;

    logic [DATA_W-1:0]    words   [ENTRIES];
    logic [NUM_SITES-1:0] sharers [ENTRIES];

    assign rd_word = words[addr];
    assign rd_shr  = sharers[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                words[i]   <= '0;
                sharers[i] <= '0;
            end
        end else begin
            if (word_we) words[addr]   <= word_wdata;
            if (shr_we)  sharers[addr] <= shr_wdata;
        end
    end
endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
    import hd_pkg::*;
#(
    parameter int NUM_SITES = 4,
    parameter int SLOTS     = 3,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int SITE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 q_valid,
    input  logic [1:0]           q_kind,
    input  logic [SITE_W-1:0]    q_site,
    input  logic [ADDR_W-1:0]    q_addr,
    input  logic [DATA_W-1:0]    q_data,
    output logic                 q_pop,
    input  logic                 ack_valid,
    input  logic                 ack_kind,
    input  logic [SITE_W-1:0]    ack_site,
    output logic [ADDR_W-1:0]    dir_addr,
    input  logic [DATA_W-1:0]    dir_word,
    input  logic [NUM_SITES-1:0] dir_shr,
    output logic                 word_we,
    output logic [DATA_W-1:0]    word_wdata,
    output logic                 shr_we,
    output logic [NUM_SITES-1:0] shr_wdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [1:0]           msg_kind,
    output logic [SITE_W-1:0]    msg_site,
    output logic [DATA_W-1:0]    msg_data
);
    hd_state_e state, state_nx;

    logic [1:0]           cur_kind;
    logic [SITE_W-1:0]    cur_site;
    logic [ADDR_W-1:0]    cur_addr;
    logic [DATA_W-1:0]    cur_data;
    logic [SITE_W-1:0]    victim;
    logic [NUM_SITES-1:0] to_send;
    logic [NUM_SITES-1:0] awaiting;

    logic [NUM_SITES-1:0] self_bit, others;
    logic                 is_sharer, is_full;
    logic [SITE_W-1:0]    purge_tgt;

    function automatic logic [SITE_W-1:0] lowest(input logic [NUM_SITES-1:0] v);
        logic [SITE_W-1:0] pick;
        pick = '0;
        for (int i = NUM_SITES - 1; i >= 0; i--) begin
            if (v[i]) pick = SITE_W'(i);
        end
        return pick;
    endfunction

    assign dir_addr  = cur_addr;
    assign self_bit  = NUM_SITES'(1) << cur_site;
    assign others    = dir_shr & ~self_bit;
    assign is_sharer = dir_shr[cur_site];
    assign is_full   = (int'($countones(dir_shr)) >= SLOTS);
    assign purge_tgt = lowest(to_send);
    assign q_pop     = (state == ST_IDLE) && q_valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx   = state;
        msg_valid  = 1'b0;
        msg_kind   = MS_DATA;
        msg_site   = cur_site;
        msg_data   = dir_word;
        word_we    = 1'b0;
        word_wdata = cur_data;
        shr_we     = 1'b0;
        shr_wdata  = dir_shr;
        unique case (state)
            ST_IDLE: begin
                if (q_valid) state_nx = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (cur_kind == RQ_WRITEBACK) begin
                    if (others != '0) begin
                        shr_we    = 1'b1;
                        shr_wdata = dir_shr & ~others;
                        state_nx  = ST_PURGE_SEND;
                    end else begin
                        state_nx  = ST_COMMIT;
                    end
                end else if (cur_kind == RQ_PUSH) begin
                    state_nx = (!is_sharer && !is_full) ? ST_REPLY : ST_IDLE;
                end else begin
                    state_nx = (is_sharer || !is_full) ? ST_REPLY : ST_DG_SEND;
                end
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                if (msg_ready) begin
                    shr_we    = 1'b1;
                    shr_wdata = dir_shr | self_bit;
                    state_nx  = ST_IDLE;
                end
            end
            ST_DG_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = MS_DEMOTE;
                msg_site  = victim;
                if (msg_ready) state_nx = ST_DG_WAIT;
            end
            ST_DG_WAIT: begin
                if (ack_valid && ack_kind == AK_DEMOTE && ack_site == victim) begin
                    shr_we    = 1'b1;
                    shr_wdata = dir_shr & ~(NUM_SITES'(1) << victim);
                    state_nx  = ST_REPLY;
                end
            end
            ST_PURGE_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = MS_PURGE;
                msg_site  = purge_tgt;
                if (msg_ready && (to_send & ~(NUM_SITES'(1) << purge_tgt)) == '0)
                    state_nx = ST_PURGE_WAIT;
            end
            ST_PURGE_WAIT: begin
                if (awaiting == '0) state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                word_we   = 1'b1;
                shr_we    = 1'b1;
                shr_wdata = self_bit;
                state_nx  = ST_RELEASE;
            end
            ST_RELEASE: begin
                msg_valid = 1'b1;
                msg_kind  = MS_RELEASE;
                msg_data  = cur_data;
                if (msg_ready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // transaction bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_kind <= '0;
            cur_site <= '0;
            cur_addr <= '0;
            cur_data <= '0;
            victim   <= '0;
            to_send  <= '0;
            awaiting <= '0;
        end else begin
            if (q_pop) begin
                cur_kind <= q_kind;
                cur_site <= q_site;
                cur_addr <= q_addr;
                cur_data <= q_data;
            end
            if (state == ST_DECIDE) begin
                victim <= lowest(dir_shr);
                if (cur_kind == RQ_WRITEBACK) to_send <= others;
            end else if (state == ST_PURGE_SEND && msg_ready) begin
                to_send[purge_tgt] <= 1'b0;
            end
            if (state == ST_DECIDE && cur_kind == RQ_WRITEBACK) begin
                awaiting <= others;
            end else if (ack_valid && ack_kind == AK_PURGE) begin
                awaiting[ack_site] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/home_dir_engine.sv
module home_dir_engine #(
    parameter int NUM_SITES  = 4,
    parameter int SLOTS      = 3,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int SITE_W     = $clog2(NUM_SITES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [SITE_W-1:0] req_site,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic              ack_kind,
    input  logic [SITE_W-1:0] ack_site,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [SITE_W-1:0] msg_site,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    localparam int REQ_W = 2 + SITE_W + ADDR_W + DATA_W;

    logic                 q_valid, q_pop;
    logic [REQ_W-1:0]     q_word;
    logic [ADDR_W-1:0]    dir_addr;
    logic [DATA_W-1:0]    dir_word, word_wdata;
    logic [NUM_SITES-1:0] dir_shr, shr_wdata;
    logic                 word_we, shr_we;

    assign ack_ready = 1'b1;
    assign msg_addr  = dir_addr;

    hd_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (req_valid),
        .wr_ready (req_ready),
        .wr_data  ({req_kind, req_site, req_addr, req_data}),
        .rd_valid (q_valid),
        .rd_pop   (q_pop),
        .rd_data  (q_word)
    );

    hd_dir #(.NUM_SITES(NUM_SITES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dir (
        .clk        (clk),
        .rst        (rst),
        .addr       (dir_addr),
        .rd_word    (dir_word),
        .rd_shr     (dir_shr),
        .word_we    (word_we),
        .word_wdata (word_wdata),
        .shr_we     (shr_we),
        .shr_wdata  (shr_wdata)
    );

    hd_ctrl #(
        .NUM_SITES(NUM_SITES), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SITE_W(SITE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .q_valid    (q_valid),
        .q_kind     (q_word[REQ_W-1 -: 2]),
        .q_site     (q_word[ADDR_W+DATA_W +: SITE_W]),
        .q_addr     (q_word[DATA_W +: ADDR_W]),
        .q_data     (q_word[DATA_W-1:0]),
        .q_pop      (q_pop),
        .ack_valid  (ack_valid),
        .ack_kind   (ack_kind),
        .ack_site   (ack_site),
        .dir_addr   (dir_addr),
        .dir_word   (dir_word),
        .dir_shr    (dir_shr),
        .word_we    (word_we),
        .word_wdata (word_wdata),
        .shr_we     (shr_we),
        .shr_wdata  (shr_wdata),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_kind   (msg_kind),
        .msg_site   (msg_site),
        .msg_data   (msg_data)
    );
endmodule

// File: rtl/hd_chk.sv
module hd_chk #(
    parameter int SITE_W = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_kind,
    input logic [SITE_W-1:0] msg_site,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [DATA_W-1:0] msg_data,
    input logic              ack_valid,
    input logic              ack_kind
);
    logic       rst_d;
    logic [7:0] purges_out;
    logic       demote_out;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            purges_out <= '0;
            demote_out <= 1'b0;
        end else begin
            purges_out <= purges_out
                + 8'(msg_valid && msg_ready && msg_kind == 2'd1)
                - 8'(ack_valid && ack_kind == 1'b0 && purges_out != '0);
            if (msg_valid && msg_ready && msg_kind == 2'd2) demote_out <= 1'b1;
            else if (ack_valid && ack_kind == 1'b1)        demote_out <= 1'b0;
        end
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> !msg_valid);

    // R9
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind)
            && $stable(msg_site) && $stable(msg_addr) && $stable(msg_data));

    // R4
    release_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 2'd3 |-> purges_out == '0);

    // R7
    reply_after_demote_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 2'd0 |-> !demote_out);
endmodule

bind home_dir_engine hd_chk #(.SITE_W(SITE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_site  (msg_site),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .ack_valid (ack_valid),
    .ack_kind  (ack_kind)
);

// File: tb/home_dir_engine_test.sv
module home_dir_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_ready;
    logic [1:0] req_kind = '0;
    logic [1:0] req_site = '0;
    logic [2:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       ack_valid = 1'b0, ack_ready;
    logic       ack_kind = 1'b0;
    logic [1:0] ack_site = '0;
    logic       msg_valid, msg_ready = 1'b0;
    logic [1:0] msg_kind, msg_site;
    logic [2:0] msg_addr;
    logic [7:0] msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    home_dir_engine uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_site(req_site), .req_addr(req_addr), .req_data(req_data),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_kind(ack_kind),
        .ack_site(ack_site),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_site(msg_site), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] k, input logic [1:0] s,
                            input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_site = s; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic send_ack(input logic k, input logic [1:0] s);
        @(negedge clk);
        ack_valid = 1'b1; ack_kind = k; ack_site = s;
        @(posedge clk);
        #1 ack_valid = 1'b0;
    endtask

    task automatic expect_msg(input string req, input logic [1:0] k, input logic [1:0] s,
                              input logic [2:0] a, input logic [7:0] d);
        int waited = 0;
        @(negedge clk);
        while (!msg_valid && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check({req, " msg offered"}, 32'(msg_valid), 32'd1);
        check({req, " kind"}, 32'(msg_kind), 32'(k));
        check({req, " site"}, 32'(msg_site), 32'(s));
        check({req, " addr"}, 32'(msg_addr), 32'(a));
        check({req, " data"}, 32'(msg_data), 32'(d));
        msg_ready = 1'b1;
        @(posedge clk);
        #1 msg_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check({req, " no message"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 msg_valid idle", 32'(msg_valid), 32'd0);
        check("R1 req_ready high", 32'(req_ready), 32'd1);
    endtask

    task automatic t_first_fetch;
        send_req(2'd0, 2'd0, 3'd1, 8'h00);
        expect_msg("R1 R2 fetch zero word", 2'd0, 2'd0, 3'd1, 8'h00);
    endtask

    task automatic t_lone_writeback;
        send_req(2'd1, 2'd0, 3'd1, 8'h55);
        expect_msg("R5 direct release", 2'd3, 2'd0, 3'd1, 8'h55);
        send_req(2'd0, 2'd1, 3'd1, 8'h00);
        expect_msg("R2 fetch site1", 2'd0, 2'd1, 3'd1, 8'h55);
        send_req(2'd0, 2'd2, 3'd1, 8'h00);
        expect_msg("R2 fetch site2", 2'd0, 2'd2, 3'd1, 8'h55);
    endtask

    task automatic t_overflow;
        send_req(2'd0, 2'd3, 3'd1, 8'h00);
        expect_msg("R7 demote lowest sharer", 2'd2, 2'd0, 3'd1, 8'h55);
        expect_quiet("R7 hold reply before demote ack", 5);
        send_ack(1'b1, 2'd0);
        expect_msg("R7 reply after demote", 2'd0, 2'd3, 3'd1, 8'h55);
    endtask

    task automatic t_purge_writeback;
        send_req(2'd1, 2'd3, 3'd1, 8'hA7);
        send_req(2'd0, 2'd0, 3'd1, 8'h00);
        expect_msg("R3 R7 purge site1 first", 2'd1, 2'd1, 3'd1, 8'h55);
        expect_msg("R3 purge site2 second", 2'd1, 2'd2, 3'd1, 8'h55);
        expect_quiet("R4 R6 held during purges", 6);
        send_ack(1'b0, 2'd1);
        expect_quiet("R4 one ack outstanding", 4);
        send_ack(1'b0, 2'd2);
        expect_msg("R4 release writer", 2'd3, 2'd3, 3'd1, 8'hA7);
        expect_msg("R6 queued fetch sees new word", 2'd0, 2'd0, 3'd1, 8'hA7);
    endtask

    task automatic t_push;
        send_req(2'd2, 2'd1, 3'd1, 8'h00);
        expect_msg("R8 push to site1", 2'd0, 2'd1, 3'd1, 8'hA7);
        send_req(2'd2, 2'd2, 3'd1, 8'h00);
        expect_quiet("R8 push to full vector ignored", 8);
        send_req(2'd2, 2'd0, 3'd1, 8'h00);
        expect_quiet("R8 push to sharer ignored", 8);
    endtask

    task automatic t_second_writer;
        send_req(2'd1, 2'd0, 3'd1, 8'h3C);
        expect_msg("R8 pushed site purged", 2'd1, 2'd1, 3'd1, 8'hA7);
        expect_msg("R3 purge old writer", 2'd1, 2'd3, 3'd1, 8'hA7);
        send_ack(1'b0, 2'd3);
        send_ack(1'b0, 2'd1);
        expect_msg("R4 release site0", 2'd3, 2'd0, 3'd1, 8'h3C);
        send_req(2'd1, 2'd0, 3'd1, 8'h11);
        expect_msg("R4 R5 sole writer released", 2'd3, 2'd0, 3'd1, 8'h11);
        send_req(2'd0, 2'd2, 3'd1, 8'h00);
        expect_msg("R4 memory holds new word", 2'd0, 2'd2, 3'd1, 8'h11);
        send_req(2'd0, 2'd2, 3'd5, 8'h00);
        expect_msg("R2 other address untouched", 2'd0, 2'd2, 3'd5, 8'h00);
    endtask

    task automatic t_backpressure;
        logic [1:0] k0, s0;
        logic [2:0] a0;
        logic [7:0] d0;
        send_req(2'd0, 2'd1, 3'd2, 8'h00);
        send_req(2'd0, 2'd1, 3'd3, 8'h00);
        send_req(2'd0, 2'd1, 3'd4, 8'h00);
        send_req(2'd0, 2'd1, 3'd6, 8'h00);
        send_req(2'd0, 2'd1, 3'd7, 8'h00);
        @(negedge clk);
        check("R9 req_ready low when full", 32'(req_ready), 32'd0);
        k0 = msg_kind; s0 = msg_site; a0 = msg_addr; d0 = msg_data;
        repeat (3) @(negedge clk);
        check("R9 msg held valid", 32'(msg_valid), 32'd1);
        check("R9 msg fields stable", {k0, s0, a0, d0}, {msg_kind, msg_site, msg_addr, msg_data});
        expect_msg("R9 order 1", 2'd0, 2'd1, 3'd2, 8'h00);
        expect_msg("R9 order 2", 2'd0, 2'd1, 3'd3, 8'h00);
        expect_msg("R9 order 3", 2'd0, 2'd1, 3'd4, 8'h00);
        expect_msg("R9 order 4", 2'd0, 2'd1, 3'd6, 8'h00);
        expect_msg("R9 order 5", 2'd0, 2'd1, 3'd7, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_first_fetch();
        t_lone_writeback();
        t_overflow();
        t_purge_writeback();
        t_push();
        t_second_writer();
        t_backpressure();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule